// File: doc/BRIEF.md
# Mode-Selectable One-Bit Stream Output Interface

This block takes the one-bit output of a delta-sigma modulator and presents it on two pins: a data line and a clock line. A two-bit mode input selects one of four configurations. The mode picks the clock source, either the fast base clock or an external clock that feeds in through the clock pin. It also picks the output clock rate, either half or a quarter of the selected clock, and sets the direction of the clock pin. Finally it decides whether the data line carries raw bits or a Manchester-coded stream for a single-wire link. A two-bit code generator divides the selected clock, an encoder forms the line signal, and a small state machine applies mode changes at clean boundaries.

The whole block runs on the base clock `clk`. In the external mode, rising edges of `ext_clk` pass through a synchronizer and an edge detector, and each detected edge advances the divider by one step. A receiver samples `data_out` on the falling edge of `clk_out`. In the synchronous modes the data therefore moves only together with a rising edge of `clk_out`.

The state machine has two states. **ST_LOAD** holds the divider at zero, forces `clk_out` low and latches the requested mode. **ST_RUN** advances the divider on every tick. The transitions are as follows. Reset enters ST_LOAD. ST_LOAD always moves to ST_RUN. ST_RUN stays in ST_RUN unless the divider wraps from 3 to 0 while the requested mode differs from the active one, in which case it moves to ST_LOAD.

Top module: `bitlink_out`

## Requirements
- R1: While `rst_n` is low and in the cycle that follows: `clk_out`=0, `data_out`=0, `clk_oe`=1, the divider is at 0 and the active mode is 00.
- R2: Mode `mode`=2'b00: the divider steps on every base cycle. `clk_out` is the half-rate clock with period 2 cycles, high for 1 cycle. On each rising edge of `clk_out`, `data_out` takes the `mod_bit` value present before that edge.
- R3: Mode 2'b01: `clk_out` is the quarter-rate clock with period 4 cycles, high for 2 cycles. `data_out` updates to `mod_bit` on each of its rising edges.
- R4: Mode 2'b10: `clk_out` is the quarter-rate bit clock. On its rising edge the bit b is captured. While `clk_out` is high, `data_out`=b. After its fall, `data_out`=~b. A 0 is thus sent low-then-high and a 1 high-then-low, with a transition at every mid-bit.
- R5: Mode 2'b11: each rising edge of `ext_clk` advances the divider by one step, after a 2-stage synchronizer and an edge detector. `data_out` captures `mod_bit` on every second such edge, so its changes are spaced by multiples of two external periods.
- R6: `clk_oe` is 0 only when the active mode is 2'b11. When `clk_oe` is 0, `clk_out` is 0.
- R7: A new `mode` value is applied only where the divider wraps from 3 to 0. One ST_LOAD cycle follows, with `clk_out` low and the divider cleared. No high phase of `clk_out` is cut short.
- R8: In modes 2'b00 and 2'b01, `data_out` changes only in a cycle where `clk_out` rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast base clock, standing in for the internal oscillator |
| rst_n | input | 1 | Synchronous active-low reset |
| ext_clk | input | 1 | External clock seen on the clock pin in mode 11 |
| mode | input | 2 | Mode code {M1,M0} |
| mod_bit | input | 1 | Modulator output bit |
| data_out | output | 1 | Data line value |
| clk_out | output | 1 | Clock pin drive value |
| clk_oe | output | 1 | Clock pin output enable |

## Verification
A mode request and a divider wrap can arrive in the same cycle. Bit capture and the mid-bit flip then fall on the same edges that decide whether ST_LOAD is entered. To provoke this, the bench changes `mode` exactly when it sees a rising edge of `clk_out`, a fixed number of cycles before the wrap. It then compares the following `clk_out` samples against a sequence worked out by hand, which shows both the completed high phase and the single quiet ST_LOAD cycle. The bench also switches modes in random order with random data. Inside each settled window it decodes the Manchester halves and measures clock periods against the mode that should be in force.

// File: rtl/bitlink_pkg.sv
package bitlink_pkg;
    localparam int DIV_W = 2;

    typedef enum logic [1:0] {
        LM_DIRECT = 2'b00,
        LM_HALF   = 2'b01,
        LM_MANCH  = 2'b10,
        LM_EXTCLK = 2'b11
    } link_mode_e;

    typedef struct packed {
        logic use_ext;
        logic slow_clk;
        logic manch;
        logic pin_drive;
    } link_ctl_t;

    typedef enum logic {
        ST_LOAD = 1'b0,
        ST_RUN  = 1'b1
    } link_state_e;
endpackage

// File: rtl/bitlink_mode_dec.sv
module bitlink_mode_dec
    import bitlink_pkg::*;
(
    input  link_mode_e mode,
    output link_ctl_t  ctl
);
    always_comb begin
        ctl = '0;
        unique case (mode)
            LM_DIRECT: ctl = '{use_ext: 1'b0, slow_clk: 1'b0, manch: 1'b0, pin_drive: 1'b1};
            LM_HALF:   ctl = '{use_ext: 1'b0, slow_clk: 1'b1, manch: 1'b0, pin_drive: 1'b1};
            LM_MANCH:  ctl = '{use_ext: 1'b0, slow_clk: 1'b1, manch: 1'b1, pin_drive: 1'b1};
            LM_EXTCLK: ctl = '{use_ext: 1'b1, slow_clk: 1'b0, manch: 1'b0, pin_drive: 1'b0};
        endcase
    end
endmodule

// File: rtl/bitlink_divgen.sv
module bitlink_divgen
    import bitlink_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ext_clk,
    input  logic             use_ext,
    input  logic             clear,
    input  logic             run,
    output logic             tick,
    output logic             wrap,
    output logic [DIV_W-1:0] cnt
);
    localparam logic [DIV_W-1:0] CNT_LAST = '1;

    logic [SYNC_STAGES-1:0] sync_q;
    logic                   edge_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q <= '0;
            edge_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[SYNC_STAGES-2:0], ext_clk};
            edge_q <= sync_q[SYNC_STAGES-1];
        end
    end

    assign tick = use_ext ? (sync_q[SYNC_STAGES-1] & ~edge_q) : 1'b1;
    assign wrap = run & tick & (cnt == CNT_LAST);

    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            cnt <= '0;
        end else if (run && tick) begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/bitlink_line_enc.sv
module bitlink_line_enc (
    input  logic clk,
    input  logic rst_n,
    input  logic capture,
    input  logic mod_bit,
    input  logic manch,
    input  logic first_half,
    output logic data_out
);
    logic bit_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bit_q <= 1'b0;
        end else if (capture) begin
            bit_q <= mod_bit;
        end
    end

    assign data_out = manch ? (first_half ? bit_q : ~bit_q) : bit_q;
endmodule

// File: rtl/bitlink_out.sv
module bitlink_out
    import bitlink_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ext_clk,
    input  logic [1:0] mode,
    input  logic       mod_bit,
    output logic       data_out,
    output logic       clk_out,
    output logic       clk_oe
);
    localparam logic [DIV_W-1:0] SLOW_PRE_RISE = DIV_W'(1);

    link_mode_e       mode_req;
    link_mode_e       active_q, active_d;
    link_state_e      state_q, state_d;
    link_ctl_t        ctl;
    logic             tick, wrap, div_clear, div_run, capture, sel_clk;
    logic [DIV_W-1:0] cnt;

    assign mode_req = link_mode_e'(mode);

    bitlink_mode_dec u_dec (
        .mode (active_q),
        .ctl  (ctl)
    );

    bitlink_divgen #(.SYNC_STAGES(2)) u_div (
        .clk     (clk),
        .rst_n   (rst_n),
        .ext_clk (ext_clk),
        .use_ext (ctl.use_ext),
        .clear   (div_clear),
        .run     (div_run),
        .tick    (tick),
        .wrap    (wrap),
        .cnt     (cnt)
    );

    bitlink_line_enc u_enc (
        .clk        (clk),
        .rst_n      (rst_n),
        .capture    (capture),
        .mod_bit    (mod_bit),
        .manch      (ctl.manch),
        .first_half (cnt[DIV_W-1]),
        .data_out   (data_out)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_LOAD;
            active_q <= LM_DIRECT;
        end else begin
            state_q  <= state_d;
            active_q <= active_d;
        end
    end

    always_comb begin
        state_d  = state_q;
        active_d = active_q;
        unique case (state_q)
            ST_LOAD: begin
                state_d  = ST_RUN;
                active_d = mode_req;
            end
            ST_RUN: begin
                if (wrap && (mode_req != active_q)) begin
                    state_d = ST_LOAD;
                end
            end
        endcase
    end

    always_comb begin
        div_clear = (state_q == ST_LOAD);
        div_run   = (state_q == ST_RUN);
        sel_clk   = ctl.slow_clk ? cnt[DIV_W-1] : cnt[0];
        capture   = div_run & tick &
                    (ctl.slow_clk ? (cnt == SLOW_PRE_RISE) : ~cnt[0]);
        clk_oe    = ctl.pin_drive;
        clk_out   = ctl.pin_drive & div_run & sel_clk;
    end
endmodule

// File: rtl/bitlink_out_chk.sv
module bitlink_out_chk
    import bitlink_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic        data_out,
    input logic        clk_out,
    input logic        clk_oe,
    input link_state_e state_q,
    input link_mode_e  active_q,
    input link_ctl_t   ctl
);
    AST_PIN_RELEASED_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !clk_oe |-> !clk_out); // R6

    AST_RELEASE_MEANS_EXT: assert property (@(posedge clk) disable iff (!rst_n)
        !clk_oe |-> ctl.use_ext); // R5

    AST_LOAD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_LOAD) |-> !clk_out); // R7

    AST_MODE_VIA_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(active_q) |-> ($past(state_q) == ST_LOAD)); // R7

    AST_FAST_HIGH_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN && clk_oe && !ctl.slow_clk && $rose(clk_out)) |=> !clk_out); // R2

    AST_SLOW_HIGH_TWO: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN && ctl.slow_clk && $rose(clk_out)) |=> clk_out); // R3

    AST_SYNC_DATA_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN && $past(state_q) == ST_RUN && !ctl.manch && !ctl.use_ext
         && !$rose(clk_out)) |-> $stable(data_out)); // R8

    AST_MANCH_MIDBIT: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN && $past(state_q) == ST_RUN && ctl.manch && $fell(clk_out))
        |-> (data_out != $past(data_out))); // R4
endmodule

bind bitlink_out bitlink_out_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .data_out (data_out),
    .clk_out  (clk_out),
    .clk_oe   (clk_oe),
    .state_q  (state_q),
    .active_q (active_q),
    .ctl      (ctl)
);

// File: tb/bitlink_out_test.sv
module bitlink_out_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ext_clk = 1'b0;
    logic [1:0] mode = 2'b00;
    logic       mod_bit = 1'b0;
    logic       data_out, clk_out, clk_oe;

    bitlink_out uut (
        .clk      (clk),
        .rst_n    (rst_n),
        .ext_clk  (ext_clk),
        .mode     (mode),
        .mod_bit  (mod_bit),
        .data_out (data_out),
        .clk_out  (clk_out),
        .clk_oe   (clk_oe)
    );

    always #10 clk = ~clk;

    int   checks = 0, fails = 0, ext_div = 0;
    bit   done = 1'b0, checking = 1'b0;
    logic prev_clk = 1'b0, prev_data = 1'b0, man_bit = 1'b0, last_rise = 1'b0;
    logic [1:0] bmode = 2'b00;
    int   since_rise = 0, since_dchg = 0;
    bit   have_rise = 1'b0, have_dchg = 1'b0, man_valid = 1'b0;

    function automatic int exp_period(input logic [1:0] m);
        return (m == 2'b01 || m == 2'b10) ? 4 : 2;
    endfunction

    function automatic string req_of(input logic [1:0] m);
        case (m)
            2'b00:   return "R2";
            2'b01:   return "R3";
            2'b10:   return "R4";
            default: return "R5";
        endcase
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic step(input bit rnd);
        logic applied, rise, fall;
        @(negedge clk);
        applied = mod_bit;
        rise = clk_out & ~prev_clk;
        fall = ~clk_out & prev_clk;
        last_rise = rise;
        if (checking) begin
            since_rise++;
            since_dchg++;
            if (bmode != 2'b11) begin
                chk(clk_oe == 1'b1, "R6", clk_oe, 1);
            end
            if (bmode == 2'b00 || bmode == 2'b01) begin
                if (rise) begin
                    if (have_rise) chk(since_rise == exp_period(bmode), req_of(bmode), since_rise, exp_period(bmode));
                    chk(data_out == applied, req_of(bmode), data_out, applied);
                    have_rise = 1'b1;
                    since_rise = 0;
                end else begin
                    chk(data_out == prev_data, "R8", data_out, prev_data);
                end
            end else if (bmode == 2'b10) begin
                if (rise) begin
                    if (have_rise) chk(since_rise == exp_period(bmode), "R4", since_rise, exp_period(bmode));
                    chk(data_out == applied, "R4", data_out, applied);
                    man_bit = applied;
                    man_valid = 1'b1;
                    have_rise = 1'b1;
                    since_rise = 0;
                end else if (fall && man_valid) begin
                    chk(data_out == ~man_bit, "R4", data_out, ~man_bit);
                end
            end else begin
                chk(clk_oe == 1'b0, "R6", clk_oe, 0);
                chk(clk_out == 1'b0, "R6", clk_out, 0);
                if (data_out != prev_data) begin
                    if (have_dchg) chk(since_dchg % 12 == 0, "R5", since_dchg, 12);
                    have_dchg = 1'b1;
                    since_dchg = 0;
                end
            end
        end
        prev_clk = clk_out;
        prev_data = data_out;
        ext_div++;
        if (ext_div == 3) begin
            ext_div = 0;
            ext_clk = ~ext_clk;
        end
        if (rnd) mod_bit = 1'($urandom % 2);
    endtask

    task automatic run_mode(input logic [1:0] m, input int n, input int hold);
        mode = m;
        checking = 1'b0;
        repeat (40) step(1'b1);
        bmode = m;
        have_rise = 1'b0;
        have_dchg = 1'b0;
        man_valid = 1'b0;
        since_rise = 0;
        since_dchg = 0;
        checking = 1'b1;
        for (int i = 0; i < n; i++) step(i % hold == 0);
        checking = 1'b0;
    endtask

    // R7: switch exactly at an observed rise, compare clk_out against a hand-derived sequence
    task automatic sw_check(input logic [1:0] to, input logic [7:0] seq, input int len);
        do step(1'b1); while (!last_rise);
        mode = to;
        for (int i = 0; i < len; i++) begin
            step(1'b1);
            chk(clk_out == seq[i], "R7", clk_out, seq[i]);
        end
    endtask

    initial begin
        void'($urandom(32'd2024));
        repeat (3) begin
            @(negedge clk);
            chk(clk_out == 1'b0, "R1", clk_out, 0);
            chk(data_out == 1'b0, "R1", data_out, 0);
            chk(clk_oe == 1'b1, "R1", clk_oe, 1);
        end
        rst_n = 1'b1;
        @(negedge clk);
        chk(clk_out == 1'b0, "R1", clk_out, 0);
        chk(clk_oe == 1'b1, "R1", clk_oe, 1);
        run_mode(2'b00, 200, 1);
        sw_check(2'b01, 8'b0110_0010, 8);
        run_mode(2'b01, 200, 1);
        sw_check(2'b00, 8'b0010_1001, 6);
        run_mode(2'b10, 300, 1);
        run_mode(2'b11, 400, 7);
        mod_bit = 1'b1;
        repeat (30) step(1'b0);
        chk(data_out == 1'b1, "R5", data_out, 1);
        mod_bit = 1'b0;
        repeat (30) step(1'b0);
        chk(data_out == 1'b0, "R5", data_out, 0);
        for (int k = 0; k < 8; k++) begin
            run_mode(2'($urandom % 4), 150, 7);
        end
        run_mode(2'b00, 100, 1);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog all-requirements actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule